// File: doc/BRIEF.md
# Request/Acknowledge Parallel Word Capture

This block samples a 32-bit parallel input word when an external requester signals that the word is valid, and stores each captured word in a small synchronous FIFO for the rest of the chip to read. The request line is asynchronous to the system clock. It passes through a two-flop synchronizer and an edge detector before any decision is made, and every latency below is counted from the synchronized rising edge.

Two capture modes are selected by `mode_hs`. In strobe mode each accepted rising edge of the request latches one word, with no reply to the requester. Edges that follow an accepted edge too closely are ignored. In handshake mode the block runs a fully interlocked exchange. The requester raises its request and holds it. The block captures the word and pushes it into the FIFO, and only then raises acknowledge, if acknowledge generation is enabled. Acknowledge stays high until the requester drops its request.

A full FIFO is handled differently in each mode. In strobe mode the word is lost and a sticky overflow flag records the loss. In handshake mode the block holds the word and withholds acknowledge until a read frees a slot. A synchronous clear empties the FIFO and resets the overflow flag before a new acquisition.

Top module: `pword_capture`

## Requirements
- R1: After reset `ack_out` is 0, `fifo_empty` is 1, `fifo_full` is 0 and `overflow` is 0.
- R2: In strobe mode (`mode_hs`=0) a rising edge of `req_in` captures `data_in`, and the word is in the FIFO (`fifo_empty`=0) after the fourth rising clock edge following the request edge. `ack_out` stays 0 in this mode.
- R3: In strobe mode a request edge that comes fewer than MIN_GAP (default 5) clock cycles after the previous accepted edge is ignored and stores nothing. An edge that comes MIN_GAP or more cycles after it is accepted.
- R4: In handshake mode (`mode_hs`=1) with `ack_en`=1, `ack_out` rises on the fourth rising clock edge after `req_in` rises, which is two cycles after the synchronized edge. It rises only when the captured word is already in the FIFO.
- R5: In handshake mode `ack_out` stays high while `req_in` stays high. It falls on the third rising clock edge after `req_in` falls, which is one cycle after the synchronized release.
- R6: With `ack_en`=0, `ack_out` is never driven high, and handshake captures still store their words.
- R7: In strobe mode a capture that finds the FIFO full drops the word and sets `overflow`. The flag stays set until a clear.
- R8: In handshake mode a capture that finds the FIFO full keeps the word, does not set `overflow` and withholds `ack_out`. The clock edge after a read frees a slot writes the word, and `ack_out` rises on that same edge.
- R9: A one-cycle `fifo_clr` pulse leaves the FIFO empty and `overflow` at 0 after the next clock edge.
- R10: The FIFO returns words in the order they were written. `rd_data` shows the oldest word while `fifo_empty`=0, `rd_en` removes it, and `fifo_full` rises when DEPTH (default 4) words are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_hs | input | 1 | 1 selects handshake mode, 0 selects strobe mode |
| ack_en | input | 1 | Enables acknowledge generation |
| fifo_clr | input | 1 | Synchronous FIFO and overflow clear |
| req_in | input | 1 | Asynchronous request from the external source |
| data_in | input | 32 | Parallel input word |
| ack_out | output | 1 | Acknowledge to the external source |
| rd_en | input | 1 | Removes the oldest word from the FIFO |
| rd_data | output | 32 | Oldest word held in the FIFO |
| fifo_empty | output | 1 | FIFO holds no word |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| overflow | output | 1 | Sticky flag: a strobe-mode word was dropped |

## Verification
The hardest case to reach is a handshake request that arrives while the FIFO is full and must wait. This needs the FIFO filled to DEPTH first. The stimulus fills it with strobe captures, switches to handshake mode and raises a request. It then checks for several cycles that acknowledge stays low and no overflow is recorded, and then reads a single word. The bench checks the cycle in which acknowledge rises and confirms that the held word comes out last, in order. The minimum-spacing rule is checked with strobe trains whose edges are one cycle too close and with trains spaced exactly at the limit.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE         = 2'd0,
        ST_CAPTURE      = 2'd1,
        ST_ACK_HOLD     = 2'd2,
        ST_WAIT_RELEASE = 2'd3
    } cap_state_e;

endpackage

// File: rtl/pwc_sync.sv
module pwc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o,
    output logic rise_o
);
    typedef struct packed {
        logic meta;
        logic lvl;
        logic prev;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.meta = async_in;
        r_d.lvl  = r_q.meta;
        r_d.prev = r_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign level_o = r_q.lvl;
    assign rise_o  = r_q.lvl & ~r_q.prev;
endmodule

// File: rtl/pwc_fifo.sv
module pwc_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fptr_t;

    fptr_t f_d, f_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_wr, do_rd;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign empty = (f_q.cnt == '0);
    assign full  = (f_q.cnt == CW'(DEPTH));
    assign do_wr = wr_en && !full;
    assign do_rd = rd_en && !empty;

    always_comb begin
        f_d = f_q;
        if (clr) begin
            f_d = '0;
        end else begin
            if (do_wr) f_d.wp = bump(f_q.wp);
            if (do_rd) f_d.rp = bump(f_q.rp);
            if (do_wr && !do_rd)      f_d.cnt = f_q.cnt + CW'(1);
            else if (do_rd && !do_wr) f_d.cnt = f_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr && !clr) mem_q[f_q.wp] <= wr_data;
    end

    assign rd_data = mem_q[f_q.rp];
endmodule

// File: rtl/pwc_ctrl.sv
module pwc_ctrl
    import pwc_pkg::*;
#(
    parameter int W       = 32,
    parameter int MIN_GAP = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_hs,
    input  logic         ack_en,
    input  logic         fifo_clr,
    input  logic         req_lvl,
    input  logic         req_rise,
    input  logic [W-1:0] data_in,
    input  logic         fifo_full,
    output logic         wr_en,
    output logic [W-1:0] wr_data,
    output logic         ack_out,
    output logic         overflow
);
    localparam int GW = $clog2(MIN_GAP + 1);

    typedef struct packed {
        cap_state_e    st;
        logic [W-1:0]  cap;
        logic [GW-1:0] gap;
        logic          ovf;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  accept;

    assign accept = req_rise && (c_q.gap == '0) && (c_q.st == ST_IDLE);

    always_comb begin
        c_d   = c_q;
        wr_en = 1'b0;
        if (c_q.gap != '0) c_d.gap = c_q.gap - GW'(1);
        unique case (c_q.st)
            ST_IDLE: begin
                if (accept) begin
                    c_d.cap = data_in;
                    c_d.gap = GW'(MIN_GAP - 1);
                    c_d.st  = ST_CAPTURE;
                end
            end
            ST_CAPTURE: begin
                if (!fifo_full) begin
                    wr_en  = 1'b1;
                    c_d.st = mode_hs ? ST_ACK_HOLD : ST_IDLE;
                end else if (!mode_hs) begin
                    c_d.ovf = 1'b1;
                    c_d.st  = ST_IDLE;
                end
            end
            ST_ACK_HOLD: begin
                if (!req_lvl) c_d.st = ST_WAIT_RELEASE;
            end
            ST_WAIT_RELEASE: begin
                c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
        if (fifo_clr) c_d.ovf = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, cap: '0, gap: '0, ovf: 1'b0};
        else        c_q <= c_d;
    end

    assign wr_data  = c_q.cap;
    assign ack_out  = ack_en && (c_q.st == ST_ACK_HOLD);
    assign overflow = c_q.ovf;
endmodule

// File: rtl/pword_capture.sv
module pword_capture #(
    parameter int W       = 32,
    parameter int DEPTH   = 4,
    parameter int MIN_GAP = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_hs,
    input  logic         ack_en,
    input  logic         fifo_clr,
    input  logic         req_in,
    input  logic [W-1:0] data_in,
    output logic         ack_out,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         fifo_empty,
    output logic         fifo_full,
    output logic         overflow
);
    logic         req_lvl, req_rise, wr_en;
    logic [W-1:0] wr_data;

    pwc_sync sync_i (
        .clk(clk), .rst_n(rst_n), .async_in(req_in),
        .level_o(req_lvl), .rise_o(req_rise)
    );

    pwc_ctrl #(.W(W), .MIN_GAP(MIN_GAP)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .mode_hs(mode_hs), .ack_en(ack_en),
        .fifo_clr(fifo_clr), .req_lvl(req_lvl), .req_rise(req_rise),
        .data_in(data_in), .fifo_full(fifo_full), .wr_en(wr_en),
        .wr_data(wr_data), .ack_out(ack_out), .overflow(overflow)
    );

    pwc_fifo #(.W(W), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .empty(fifo_empty), .full(fifo_full)
    );
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker (
    input logic clk,
    input logic rst_n,
    input logic ack_en,
    input logic fifo_clr,
    input logic req_lvl,
    input logic ack_out,
    input logic fifo_empty,
    input logic fifo_full,
    input logic overflow
);
    // R5: acknowledge held while the synchronized request is high
    a_r5_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_out && req_lvl) |=> (ack_out || !ack_en));

    // R5: acknowledge drops one cycle after the synchronized release
    a_r5_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_out && !req_lvl) |=> !ack_out);

    // R4: acknowledge only rises with the word already stored
    a_r4_ack_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_out) && !$rose(ack_en)) |-> !fifo_empty);

    // R7: overflow is sticky until a clear
    a_r7_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !fifo_clr) |=> overflow);

    // R9: clear empties the FIFO and the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |=> (fifo_empty && !overflow));

    // R10: full and empty never together
    a_r10_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_empty);
endmodule

bind pword_capture pwc_checker chk_i (
    .clk(clk), .rst_n(rst_n), .ack_en(ack_en), .fifo_clr(fifo_clr),
    .req_lvl(req_lvl), .ack_out(ack_out), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .overflow(overflow)
);

// File: tb/pword_capture_tb_top.sv
module pword_capture_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_hs = 1'b0, ack_en = 1'b1, fifo_clr = 1'b0;
    logic        req_in = 1'b0, rd_en = 1'b0;
    logic [31:0] data_in = '0;
    logic        ack_out, fifo_empty, fifo_full, overflow;
    logic [31:0] rd_data;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    logic [31:0] exp_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pword_capture dut_i (
        .clk(clk), .rst_n(rst_n), .mode_hs(mode_hs), .ack_en(ack_en),
        .fifo_clr(fifo_clr), .req_in(req_in), .data_in(data_in),
        .ack_out(ack_out), .rd_en(rd_en), .rd_data(rd_data),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .overflow(overflow)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one strobe pulse; expected word queued only if it should be stored
    task automatic strobe(input logic [31:0] w, input int hi, input int lo, input bit keep);
        data_in = w;
        req_in  = 1'b1;
        if (keep) exp_q.push_back(w);
        tick(hi);
        req_in = 1'b0;
        tick(lo);
    endtask

    // monitor: pop every stored word and compare against the scoreboard
    task automatic drain(input string tag);
        logic [31:0] e;
        while (!fifo_empty) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, tag, rd_data, 32'hx);
            end else begin
                e = exp_q.pop_front();
                chk(rd_data === e, tag, rd_data, e);
            end
            rd_en = 1'b1;
            tick(1);
            rd_en = 1'b0;
        end
        chk(exp_q.size() == 0, {tag, " missing words"}, 32'(exp_q.size()), 0);
        exp_q.delete();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk(ack_out == 0 && fifo_empty == 1 && fifo_full == 0 && overflow == 0,
            "R1 reset", {28'd0, ack_out, fifo_empty, fifo_full, overflow}, 32'h4);

        // R2 strobe capture timing
        data_in = 32'hA5A5_0001;
        req_in  = 1'b1;
        exp_q.push_back(32'hA5A5_0001);
        tick(3);
        chk(fifo_empty == 1, "R2 not yet stored", 32'(fifo_empty), 1);
        tick(1);
        chk(fifo_empty == 0, "R2 stored", 32'(fifo_empty), 0);
        chk(ack_out == 0, "R2 no ack in strobe", 32'(ack_out), 0);
        req_in = 1'b0;
        tick(6);
        drain("R2 word");

        // R3 edges 4 cycles apart: middle one ignored
        strobe(32'h0000_0011, 2, 2, 1);
        strobe(32'h0000_0022, 2, 2, 0);
        strobe(32'h0000_0033, 2, 2, 1);
        tick(6);
        drain("R3 close edges");
        // R3 edges exactly MIN_GAP apart: all accepted
        strobe(32'h0000_0044, 2, 3, 1);
        strobe(32'h0000_0055, 2, 3, 1);
        strobe(32'h0000_0066, 2, 3, 1);
        tick(6);
        drain("R3 edges at limit");

        // R4/R5 handshake
        mode_hs = 1'b1;
        data_in = 32'hC0DE_0004;
        req_in  = 1'b1;
        exp_q.push_back(32'hC0DE_0004);
        tick(3);
        chk(ack_out == 0, "R4 ack not early", 32'(ack_out), 0);
        tick(1);
        chk(ack_out == 1, "R4 ack rises", 32'(ack_out), 1);
        chk(fifo_empty == 0, "R4 word before ack", 32'(fifo_empty), 0);
        tick(5);
        chk(ack_out == 1, "R5 ack held", 32'(ack_out), 1);
        req_in = 1'b0;
        tick(2);
        chk(ack_out == 1, "R5 ack until sync release", 32'(ack_out), 1);
        tick(1);
        chk(ack_out == 0, "R5 ack dropped", 32'(ack_out), 0);
        tick(3);
        drain("R4 handshake word");

        // R6 acknowledge disabled
        ack_en  = 1'b0;
        data_in = 32'hD15A_0006;
        req_in  = 1'b1;
        exp_q.push_back(32'hD15A_0006);
        for (int i = 0; i < 8; i++) begin
            tick(1);
            chk(ack_out == 0, "R6 ack never driven", 32'(ack_out), 0);
        end
        req_in = 1'b0;
        tick(5);
        drain("R6 word stored");
        ack_en = 1'b1;

        // R7 strobe overflow
        mode_hs = 1'b0;
        for (int i = 0; i < 5; i++) strobe(32'h7000_0000 + 32'(i), 2, 4, i < 4);
        tick(4);
        chk(fifo_full == 1, "R10 full at depth", 32'(fifo_full), 1);
        chk(overflow == 1, "R7 overflow set", 32'(overflow), 1);
        drain("R7 first words kept");
        chk(overflow == 1, "R7 overflow sticky", 32'(overflow), 1);

        // R9 clear
        strobe(32'h9999_0009, 2, 4, 0);
        chk(fifo_empty == 0, "R9 word present before clear", 32'(fifo_empty), 0);
        fifo_clr = 1'b1;
        tick(1);
        fifo_clr = 1'b0;
        chk(fifo_empty == 1 && overflow == 0, "R9 cleared",
            {30'd0, fifo_empty, overflow}, 32'h2);

        // R8 handshake waits on full FIFO
        for (int i = 0; i < 4; i++) strobe(32'h8000_0000 + 32'(i), 2, 4, 1);
        tick(3);
        mode_hs = 1'b1;
        data_in = 32'h8888_0008;
        req_in  = 1'b1;
        tick(8);
        chk(ack_out == 0, "R8 ack withheld", 32'(ack_out), 0);
        chk(overflow == 0, "R8 no overflow", 32'(overflow), 0);
        chk(rd_data === exp_q[0], "R10 oldest word shown", rd_data, exp_q[0]);
        void'(exp_q.pop_front());
        rd_en = 1'b1;
        tick(1);
        rd_en = 1'b0;
        chk(ack_out == 0, "R8 ack not before write", 32'(ack_out), 0);
        tick(1);
        chk(ack_out == 1, "R8 ack after space", 32'(ack_out), 1);
        exp_q.push_back(32'h8888_0008);
        req_in = 1'b0;
        tick(5);
        drain("R8 held word in order");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule